// File: doc/BRIEF.md
# Sync Frame Length Checker

This block supervises frame alignment against an external sync pulse. The sync line is sampled on the falling edge of the device clock, and each rising edge found there restarts an internal frame position counter. The counter also announces that restart to the rest of the chip. The counter length is fixed by a parameter: 2048 device clocks by default, which is one 8 kHz frame at 16.384 MHz. Every sync edge after the first is checked against the frame boundary the counter predicts.

A state machine turns these checks into a lock decision. It confirms lock after a run of correctly spaced edges and drops lock at the first boundary that is missed or the first edge that arrives off the boundary. A status output always shows the present lock state. Every entry into lock and every exit from it sets a sticky interrupt flag, which stays set until the host clears it. The check keeps running for as long as the block is out of reset.

Top module: `sfl_frame_checker`

## Requirements
- R1: `sync_in` is sampled on the falling edge of `clk`. When a sample is high and the previous one was low, `frame_restart` is high for exactly one cycle: the cycle after the first rising `clk` edge that follows the high sample.
- R2: While reset is held and right after it is released, `in_sync`, `irq` and `frame_restart` are all 0.
- R3: The first sync edge after reset only aligns the frame counter. It pulses `frame_restart` but leaves `in_sync` at 0 and does not set `irq`.
- R4: An edge is correct when it is registered exactly FRAME_LEN clock cycles after the previous alignment. CONFIRM_EDGES consecutive correct edges (default 2) set `in_sync` to 1 and set `irq`.
- R5: While `in_sync` is 1, further correct edges keep it at 1 and do not set `irq` again.
- R6: If no edge is registered at the boundary FRAME_LEN cycles after alignment, the block clears `in_sync` (if it was 1) and sets `irq`. The counter then wraps, so an edge FRAME_LEN cycles after the missed boundary counts as correct.
- R7: An edge that arrives early or late clears `in_sync` (if it was 1) and sets `irq` when lock is lost. It also realigns the counter, so the next correct edge comes FRAME_LEN cycles after it.
- R8: After lock is lost, lock returns only after CONFIRM_EDGES new consecutive correct edges. The return sets `irq`.
- R9: `irq` holds at 1 until `irq_clr` is high at a clock edge. A lock change in that same cycle wins over the clear, and `irq` stays at 1.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Device clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| sync_in | input | 1 | External frame sync pulse |
| irq_clr | input | 1 | Host clear for the interrupt flag |
| frame_restart | output | 1 | One-cycle pulse when a sync edge restarts the frame counter |
| in_sync | output | 1 | 1 while frame lock is held |
| irq | output | 1 | Sticky flag set on every gain or loss of lock |

## Verification
The bench places edges exactly on the boundary, five cycles early and five cycles late. It also skips an edge entirely. A design that restarts its count at a missed boundary, or keeps counting from the old alignment after an early edge, would then misjudge the next on-time edge and never relock when expected. The bench raises the clear in the very cycle that lock returns, which catches a clear given priority over the set. It also checks that a sync pulse several cycles wide gives a single restart at the cycle that falling-edge sampling predicts, which catches both edge-detection and sampling-phase mistakes.

// File: rtl/sfl_pkg.sv
package sfl_pkg;
   typedef enum logic [1:0] {
      SFL_HUNT    = 2'd0,
      SFL_CONFIRM = 2'd1,
      SFL_LOCKED  = 2'd2
   } sfl_state_e;
endpackage

// File: rtl/sfl_sync_sampler.sv
// Samples the sync line on the chosen clock edge and flags a low-to-high
// change between two successive samples.
module sfl_sync_sampler #(
   parameter bit SAMPLE_FALLING = 1'b1
) (
   input  logic clk,
   input  logic rst_n,
   input  logic sync_in,
   output logic edge_o
);
   logic samp_q;
   logic prev_q;

   generate
      if (SAMPLE_FALLING) begin : g_fall
         always_ff @(negedge clk or negedge rst_n) begin
            if (!rst_n) samp_q <= 1'b0;
            else        samp_q <= sync_in;
         end
      end else begin : g_rise
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) samp_q <= 1'b0;
            else        samp_q <= sync_in;
         end
      end
   endgenerate

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) prev_q <= 1'b0;
      else        prev_q <= samp_q;
   end

   assign edge_o = samp_q & ~prev_q;
endmodule

// File: rtl/sfl_frame_counter.sv
// Frame position counter: idle until the first sync edge, then free
// running modulo FRAME_LEN, realigned to zero by every sync edge.
module sfl_frame_counter #(
   parameter int unsigned FRAME_LEN = 2048,
   localparam int unsigned CW = (FRAME_LEN > 1) ? $clog2(FRAME_LEN) : 1
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          edge_i,
   output logic          armed_o,
   output logic          at_bnd_o,
   output logic [CW-1:0] pos_o
);
   localparam logic [CW-1:0] LAST = CW'(FRAME_LEN - 1);

   logic          armed_q;
   logic [CW-1:0] pos_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         armed_q <= 1'b0;
         pos_q   <= '0;
      end else if (edge_i) begin
         armed_q <= 1'b1;
         pos_q   <= '0;
      end else if (armed_q) begin
         pos_q   <= (pos_q == LAST) ? '0 : pos_q + 1'b1;
      end
   end

   assign armed_o  = armed_q;
   assign at_bnd_o = armed_q && (pos_q == LAST);
   assign pos_o    = pos_q;
endmodule

// File: rtl/sfl_lock_fsm.sv
// Lock state machine with a sticky change flag.
module sfl_lock_fsm
   import sfl_pkg::*;
#(
   parameter int unsigned CONFIRM_EDGES = 2,
   localparam int unsigned QW = $clog2(CONFIRM_EDGES + 1)
) (
   input  logic clk,
   input  logic rst_n,
   input  logic edge_i,
   input  logic armed_i,
   input  logic at_bnd_i,
   input  logic irq_clr_i,
   output logic in_sync_o,
   output logic irq_o
);
   localparam logic [QW-1:0] OK_LAST = QW'(CONFIRM_EDGES - 1);

   sfl_state_e    state_q, state_d;
   logic [QW-1:0] ok_q, ok_d;
   logic          irq_q;
   logic          good, bad, change;

   assign good = edge_i & at_bnd_i;
   assign bad  = armed_i & (edge_i ^ at_bnd_i);

   always_comb begin
      state_d = state_q;
      ok_d    = ok_q;
      unique case (state_q)
         SFL_HUNT: begin
            if (edge_i) begin
               state_d = SFL_CONFIRM;
               ok_d    = '0;
            end
         end
         SFL_CONFIRM: begin
            if (good) begin
               if (ok_q == OK_LAST) begin
                  state_d = SFL_LOCKED;
                  ok_d    = '0;
               end else begin
                  ok_d = ok_q + 1'b1;
               end
            end else if (bad) begin
               ok_d = '0;
            end
         end
         SFL_LOCKED: begin
            if (bad) begin
               state_d = SFL_CONFIRM;
               ok_d    = '0;
            end
         end
         default: begin
            state_d = SFL_HUNT;
            ok_d    = '0;
         end
      endcase
   end

   assign change = (state_q != state_d) &&
                   ((state_q == SFL_LOCKED) || (state_d == SFL_LOCKED));

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state_q <= SFL_HUNT;
         ok_q    <= '0;
         irq_q   <= 1'b0;
      end else begin
         state_q <= state_d;
         ok_q    <= ok_d;
         if (change)         irq_q <= 1'b1;
         else if (irq_clr_i) irq_q <= 1'b0;
      end
   end

   assign in_sync_o = (state_q == SFL_LOCKED);
   assign irq_o     = irq_q;
endmodule

// File: rtl/sfl_frame_checker.sv
module sfl_frame_checker #(
   parameter int unsigned FRAME_LEN      = 2048,
   parameter int unsigned CONFIRM_EDGES  = 2,
   parameter bit          SAMPLE_FALLING = 1'b1,
   localparam int unsigned CW = (FRAME_LEN > 1) ? $clog2(FRAME_LEN) : 1
) (
   input  logic clk,
   input  logic rst_n,
   input  logic sync_in,
   input  logic irq_clr,
   output logic frame_restart,
   output logic in_sync,
   output logic irq
);
   generate
      if (FRAME_LEN < 8) begin : g_bad_len
         $error("FRAME_LEN must be at least 8");
      end
      if (CONFIRM_EDGES < 1) begin : g_bad_conf
         $error("CONFIRM_EDGES must be at least 1");
      end
   endgenerate

   logic          edge_w;
   logic          armed_w;
   logic          at_bnd_w;
   logic [CW-1:0] pos_w;
   logic          restart_q;

   sfl_sync_sampler #(.SAMPLE_FALLING(SAMPLE_FALLING)) u_samp (
      .clk     (clk),
      .rst_n   (rst_n),
      .sync_in (sync_in),
      .edge_o  (edge_w)
   );

   sfl_frame_counter #(.FRAME_LEN(FRAME_LEN)) u_cnt (
      .clk      (clk),
      .rst_n    (rst_n),
      .edge_i   (edge_w),
      .armed_o  (armed_w),
      .at_bnd_o (at_bnd_w),
      .pos_o    (pos_w)
   );

   sfl_lock_fsm #(.CONFIRM_EDGES(CONFIRM_EDGES)) u_fsm (
      .clk       (clk),
      .rst_n     (rst_n),
      .edge_i    (edge_w),
      .armed_i   (armed_w),
      .at_bnd_i  (at_bnd_w),
      .irq_clr_i (irq_clr),
      .in_sync_o (in_sync),
      .irq_o     (irq)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) restart_q <= 1'b0;
      else        restart_q <= edge_w;
   end

   assign frame_restart = restart_q;
endmodule

// File: rtl/sfl_frame_checker_sva.sv
module sfl_frame_checker_sva #(
   parameter int unsigned FRAME_LEN = 2048,
   parameter int unsigned CW        = 11
) (
   input logic          clk,
   input logic          rst_n,
   input logic          irq_clr,
   input logic          frame_restart,
   input logic          in_sync,
   input logic          irq,
   input logic          edge_pulse,
   input logic          armed,
   input logic          at_bnd,
   input logic [CW-1:0] frame_pos
);
   a_r1_single_restart: assert property (@(posedge clk) disable iff (!rst_n)
      frame_restart |=> !frame_restart);

   a_r3_first_edge_no_lock: assert property (@(posedge clk) disable iff (!rst_n)
      !armed |=> !in_sync);

   a_r4_lock_on_edge: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(in_sync) |-> $past(edge_pulse));

   a_r6_missing_drops: assert property (@(posedge clk) disable iff (!rst_n)
      (in_sync && at_bnd && !edge_pulse) |=> !in_sync);

   a_r7_edge_realigns: assert property (@(posedge clk) disable iff (!rst_n)
      edge_pulse |=> (frame_pos == '0));

   a_r6_pos_bounded: assert property (@(posedge clk) disable iff (!rst_n)
      frame_pos <= CW'(FRAME_LEN - 1));

   a_r9_irq_sticky: assert property (@(posedge clk) disable iff (!rst_n)
      (irq && !irq_clr) |=> irq);

   a_r9_change_flags: assert property (@(posedge clk) disable iff (!rst_n)
      (in_sync != $past(in_sync)) |-> irq);
endmodule

bind sfl_frame_checker sfl_frame_checker_sva #(.FRAME_LEN(FRAME_LEN), .CW(CW)) u_sva (
   .clk           (clk),
   .rst_n         (rst_n),
   .irq_clr       (irq_clr),
   .frame_restart (frame_restart),
   .in_sync       (in_sync),
   .irq           (irq),
   .edge_pulse    (edge_w),
   .armed         (armed_w),
   .at_bnd        (at_bnd_w),
   .frame_pos     (pos_w)
);

// File: tb/sfl_frame_checker_tb_top.sv
module sfl_frame_checker_tb_top;
   localparam int CLK_PERIOD = 10;
   localparam int FLEN       = 256;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic sync_in = 1'b0;
   logic irq_clr = 1'b0;
   logic frame_restart, in_sync, irq;

   int cyc = 0;
   int n_checks = 0;
   int n_fail = 0;
   bit done = 1'b0;

   typedef struct {
      int    at;
      bit    e_sync;
      bit    e_irq;
      bit    e_rst;
      string tag;
   } item_t;

   item_t sb_q[$];

   always #(CLK_PERIOD/2) clk = ~clk;

   always @(posedge clk) cyc <= cyc + 1;

   sfl_frame_checker #(.FRAME_LEN(FLEN), .CONFIRM_EDGES(2), .SAMPLE_FALLING(1'b1)) dut_i (
      .clk           (clk),
      .rst_n         (rst_n),
      .sync_in       (sync_in),
      .irq_clr       (irq_clr),
      .frame_restart (frame_restart),
      .in_sync       (in_sync),
      .irq           (irq)
   );

   function automatic void sb_push(input int at, input bit es, input bit ei,
                                   input bit er, input string tag);
      item_t it;
      it.at = at; it.e_sync = es; it.e_irq = ei; it.e_rst = er; it.tag = tag;
      sb_q.push_back(it);
   endfunction

   // Monitor: compares outputs against queued expectations, away from clock edges
   always @(posedge clk) begin
      #2;
      while (sb_q.size() > 0 && sb_q[0].at <= cyc) begin
         item_t it;
         it = sb_q.pop_front();
         n_checks++;
         if (it.at < cyc) begin
            n_fail++;
            $display("FAIL %s: expectation for cycle %0d missed (now %0d)", it.tag, it.at, cyc);
         end else if (in_sync !== it.e_sync || irq !== it.e_irq || frame_restart !== it.e_rst) begin
            n_fail++;
            $display("FAIL %s @%0d: in_sync/irq/restart got %b%b%b expected %b%b%b",
                     it.tag, cyc, in_sync, irq, frame_restart, it.e_sync, it.e_irq, it.e_rst);
         end
      end
   end

   // Driver: one frame slot; gap counts cycles since the previous slot start
   task automatic frame(input int gap, input bit do_edge, input bit clr_with,
                        input bit es, input bit ei, input string tag);
      repeat (gap - 3) @(posedge clk);
      #1;
      if (do_edge)  sync_in = 1'b1;
      if (clr_with) irq_clr = 1'b1;
      sb_push(cyc + 1, es, ei, do_edge, tag);
      sb_push(cyc + 3, es, ei, 1'b0, tag);
      @(posedge clk); #1 irq_clr = 1'b0;
      repeat (2) @(posedge clk);
      #1 sync_in = 1'b0;
   endtask

   task automatic clear(input bit es, input string tag);
      irq_clr = 1'b1;
      sb_push(cyc + 1, es, 1'b0, 1'b0, tag);
      @(posedge clk); #1 irq_clr = 1'b0;
      @(posedge clk); #1;
   endtask

   initial begin
      repeat (3) @(posedge clk);
      #1 rst_n = 1'b1;
      sb_push(cyc + 1, 1'b0, 1'b0, 1'b0, "R2 reset state");
      // R3: first edge only aligns; R1: restart one cycle after the sample
      frame(10,   1, 0, 0, 0, "R3 R1 first edge");
      frame(FLEN, 1, 0, 0, 0, "R4 first correct edge");
      frame(FLEN, 1, 0, 1, 1, "R4 lock achieved");
      clear(1, "R9 host clear");
      frame(FLEN - 2, 1, 0, 1, 0, "R5 locked edge");
      frame(FLEN,     1, 0, 1, 0, "R5 locked edge 2");
      frame(FLEN,     0, 0, 0, 1, "R6 missing edge loses lock");
      clear(0, "R9 clear after loss");
      frame(FLEN - 2, 1, 0, 0, 0, "R6 wrap keeps phase");
      frame(FLEN,     1, 1, 1, 1, "R8 R9 relock beats clear");
      clear(1, "R9 clear after relock");
      frame(FLEN - 2 - 5, 1, 0, 0, 1, "R7 early edge loses lock");
      clear(0, "R9 clear after early");
      frame(FLEN - 2, 1, 0, 0, 0, "R7 realigned to early edge");
      frame(FLEN,     1, 0, 1, 1, "R8 relock after early");
      clear(1, "R9 clear");
      frame(FLEN - 2, 0, 0, 0, 1, "R6 missing before late edge");
      frame(5,        1, 0, 0, 1, "R7 late edge realigns");
      frame(FLEN,     1, 0, 0, 1, "R7 first edge after late");
      frame(FLEN,     1, 0, 1, 1, "R8 relock after late");
      repeat (6) @(posedge clk);
      #3;
      if (sb_q.size() != 0) begin
         n_checks++; n_fail++;
         $display("FAIL scoreboard: %0d expectations left, expected 0", sb_q.size());
      end
      done = 1'b1;
      $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
      $finish;
   end

   initial begin
      repeat (20000) @(posedge clk);
      if (!done) begin
         n_checks++; n_fail++;
         $display("FAIL watchdog: run did not complete, expected completion");
         $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
         $finish;
      end
   end
endmodule